// File: doc/BRIEF.md
# Masked Simultaneous-Sampling Conversion Sequencer

This block stands for one eight-channel converter slot. A start pulse freezes the sample values of every channel in the same clock edge. The slot then converts the channels that its enable mask selects, one after another, from the lowest channel number upward. Each finished result goes into a result queue. Software empties the queue one word per read strobe.

Conversion time is modelled in clock cycles. The first result takes one latency, and every later enabled channel adds a fixed step, so each disabled channel makes the sequence shorter. Two flags report progress. The first-result flag goes high when the lowest enabled channel's result can be read. The last-result flag goes high when the whole sequence is complete. A new start clears both flags and the queue, unless a sequence is already running, in which case the start is ignored.

Top module: `msamp_seq`

## Requirements
- R1: After reset the enable mask is all ones, both flags are low, and the read word is 16'hFFFF. A start with no mask write converts all eight channels.
- R2: Mask bit n set to 1 enables channel n. A disabled channel is never converted and never appears in the read data.
- R3: Successive reads return the enabled channels' results in ascending channel order, one word for each enabled channel. A read with the queue empty returns 16'hFFFF and leaves the queue unchanged.
- R4: Every result word carries the 12-bit result in bits 11:0, with bit 0 as the LSB, and ones in bits 15:12.
- R5: The first-result flag rises exactly FIRST_CYC clock edges after the edge that accepts the start.
- R6: The last-result flag rises exactly FIRST_CYC + (n-1)*PER_CYC edges after the accepted start, where n is the number of enabled channels. It is never high while the first-result flag is low.
- R7: All channel samples are captured at the accepted start edge. Later changes on the sample input do not affect that sequence's results.
- R8: An accepted start clears both flags and empties the queue, so old results can no longer be read.
- R9: A start that arrives while a sequence runs is ignored. The flags, the timing and the results of the running sequence are unchanged.
- R10: A start with an all-zero mask produces no result and no flag, and the queue stays empty.
- R11: A mask written during a sequence takes effect only at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_we_i | input | 1 | Writes mask_d_i into the enable mask |
| mask_d_i | input | NCH (8) | New enable mask, bit n for channel n |
| start_i | input | 1 | Start pulse for a sequence |
| samp_i | input | NCH*DW (96) | Per-channel sample values, channel n in bits n*DW +: DW |
| rd_i | input | 1 | Read strobe; consumes the word shown on rd_word_o |
| rd_word_o | output | WW (16) | Head of the result queue, or all ones when the queue is empty |
| eoc_o | output | 1 | First result ready |
| eolc_o | output | 1 | Last result ready |

## Verification
The bench builds the slot with FIRST_CYC = 4 and PER_CYC = 2. With these values a full eight-channel sequence takes 18 cycles, so the bench can compare every cycle of each sequence against the expected flag values and still test many masks. The short first latency also makes it easy to send a second start while results are still arriving and a mask write while the sequence runs. The default values, which approximate the nanosecond figures at 15 MHz, are only elaborated.

// File: rtl/msamp_pkg.sv
package msamp_pkg;

   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } sq_state_e;

   // Width of a down-counter that must hold values up to maxv
   function automatic int cnt_bits(input int maxv);
      cnt_bits = (maxv < 2) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/msamp_mask.sv
module msamp_mask #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_i,
   input  logic [NCH-1:0] d_i,
   output logic [NCH-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '1;
      else if (we_i) q_o <= d_i;
   end

endmodule

// File: rtl/msamp_snap.sv
module msamp_snap #(
   parameter int NCH = 8,
   parameter int DW  = 12,
   localparam int CHW = (NCH < 2) ? 1 : $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [NCH*DW-1:0] samp_i,
   input  logic [CHW-1:0]    sel_i,
   output logic [DW-1:0]     data_o
);

   logic [DW-1:0] held_q [NCH];

   // One holding register per channel, all loaded on the same edge
   for (genvar g = 0; g < NCH; g++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         held_q[g] <= '0;
         else if (capture_i) held_q[g] <= samp_i[g*DW +: DW];
      end
   end

   assign data_o = held_q[sel_i];

endmodule

// File: rtl/msamp_fifo.sv
module msamp_fifo #(
   parameter int DEPTH = 8,
   parameter int DW    = 12,
   localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          push_i,
   input  logic [DW-1:0] din_i,
   input  logic          pop_i,
   output logic [DW-1:0] dout_o,
   output logic          empty_o
);

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          do_pop;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty_o = (cnt_q == '0);
   assign do_pop  = pop_i && !empty_o;
   assign dout_o  = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (push_i) mem_q[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wp_q <= bump(wp_q);
         if (do_pop) rp_q <= bump(rp_q);
         case ({push_i, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/msamp_ctrl.sv
module msamp_ctrl
   import msamp_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int FIRST_CYC = 14,
   parameter int PER_CYC   = 3,
   localparam int CHW = (NCH < 2) ? 1 : $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [NCH-1:0] mask_i,
   output logic           capture_o,
   output logic           busy_o,
   output logic           push_o,
   output logic [CHW-1:0] ch_o,
   output logic           eoc_o,
   output logic           eolc_o
);

   localparam int MAXC = (FIRST_CYC > PER_CYC) ? FIRST_CYC : PER_CYC;
   localparam int CNTW = cnt_bits(MAXC);

   sq_state_e      state_q;
   logic [NCH-1:0] left_q, left_nxt;
   logic [CNTW-1:0] cnt_q;

   // Lowest set bit of the channels still waiting
   function automatic logic [CHW-1:0] low_idx(input logic [NCH-1:0] v);
      low_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (v[i]) low_idx = CHW'(i);
      end
   endfunction

   assign busy_o    = (state_q == SQ_RUN);
   assign capture_o = start_i && !busy_o;
   assign ch_o      = low_idx(left_q);
   assign push_o    = busy_o && (cnt_q == '0);
   assign left_nxt  = left_q & ~(NCH'(1) << ch_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         left_q  <= '0;
         cnt_q   <= '0;
         eoc_o   <= 1'b0;
         eolc_o  <= 1'b0;
      end else if (capture_o) begin
         state_q <= (|mask_i) ? SQ_RUN : SQ_IDLE;
         left_q  <= mask_i;
         cnt_q   <= CNTW'(FIRST_CYC - 1);
         eoc_o   <= 1'b0;
         eolc_o  <= 1'b0;
      end else if (busy_o) begin
         if (push_o) begin
            left_q <= left_nxt;
            eoc_o  <= 1'b1;
            if (left_nxt == '0) begin
               state_q <= SQ_IDLE;
               eolc_o  <= 1'b1;
            end else begin
               cnt_q <= CNTW'(PER_CYC - 1);
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/msamp_seq.sv
module msamp_seq #(
   parameter int NCH       = 8,
   parameter int DW        = 12,
   parameter int WW        = 16,
   parameter int FIRST_CYC = 14,
   parameter int PER_CYC   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we_i,
   input  logic [NCH-1:0]    mask_d_i,
   input  logic              start_i,
   input  logic [NCH*DW-1:0] samp_i,
   input  logic              rd_i,
   output logic [WW-1:0]     rd_word_o,
   output logic              eoc_o,
   output logic              eolc_o
);

   localparam int CHW = (NCH < 2) ? 1 : $clog2(NCH);
   localparam int PAD = WW - DW;

   if (NCH < 2)       begin : g_bad_nch   $error("NCH must be at least 2");        end
   if (PAD < 1)       begin : g_bad_ww    $error("WW must exceed DW");             end
   if (FIRST_CYC < 1) begin : g_bad_first $error("FIRST_CYC must be at least 1");  end
   if (PER_CYC < 1)   begin : g_bad_per   $error("PER_CYC must be at least 1");    end

   logic [NCH-1:0] mask_q;
   logic           capture;
   logic           seq_busy;
   logic           push;
   logic [CHW-1:0] cur_ch;
   logic [DW-1:0]  cur_data;
   logic [DW-1:0]  q_head;
   logic           q_empty;

   msamp_mask #(.NCH(NCH)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (mask_we_i),
      .d_i   (mask_d_i),
      .q_o   (mask_q)
   );

   msamp_ctrl #(.NCH(NCH), .FIRST_CYC(FIRST_CYC), .PER_CYC(PER_CYC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mask_i    (mask_q),
      .capture_o (capture),
      .busy_o    (seq_busy),
      .push_o    (push),
      .ch_o      (cur_ch),
      .eoc_o     (eoc_o),
      .eolc_o    (eolc_o)
   );

   msamp_snap #(.NCH(NCH), .DW(DW)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .samp_i    (samp_i),
      .sel_i     (cur_ch),
      .data_o    (cur_data)
   );

   msamp_fifo #(.DEPTH(NCH), .DW(DW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (capture),
      .push_i  (push),
      .din_i   (cur_data),
      .pop_i   (rd_i),
      .dout_o  (q_head),
      .empty_o (q_empty)
   );

   assign rd_word_o = q_empty ? '1 : {{PAD{1'b1}}, q_head};

endmodule

// File: rtl/msamp_seq_chk.sv
module msamp_seq_chk #(
   parameter int DW = 12,
   parameter int WW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [WW-1:0] rd_word_o,
   input logic          eoc_o,
   input logic          eolc_o,
   input logic          busy_i
);

   // R6: the completion flag never stands without the first-result flag
   p_eolc_with_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eolc_o |-> eoc_o);

   // R4: the bits above the result field always read as ones
   p_fill_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_word_o[WW-1:DW] == '1);

   // R3: no result is readable before the first result is flagged
   p_empty_before_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_o |-> rd_word_o == '1);

   // R8: an accepted start drops both flags on the next edge
   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_i) |=> (!eoc_o && !eolc_o));

   // R9: a start during a running sequence leaves the first-result flag set
   p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_i && eoc_o) |=> eoc_o);

   // R5: the first-result flag only rises out of a running sequence
   p_eoc_rise_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_o) |-> $past(busy_i));

endmodule

bind msamp_seq msamp_seq_chk #(.DW(DW), .WW(WW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .rd_word_o (rd_word_o),
   .eoc_o     (eoc_o),
   .eolc_o    (eolc_o),
   .busy_i    (seq_busy)
);

// File: tb/msamp_seq_tb_top.sv
module msamp_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 8;
   localparam int DW    = 12;
   localparam int FIRST = 4;
   localparam int PER   = 2;

   // Each entry: {mask[11:4], expected enabled count[3:0]}
   localparam logic [11:0] VEC [6] = '{
      {8'hFF, 4'd8}, {8'h21, 4'd2}, {8'h80, 4'd1},
      {8'h01, 4'd1}, {8'h5A, 4'd4}, {8'hE7, 4'd6}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mask_we_i = 1'b0;
   logic [NCH-1:0]    mask_d_i = '0;
   logic              start_i = 1'b0;
   logic [NCH*DW-1:0] samp_i = '0;
   logic              rd_i = 1'b0;
   logic [15:0]       rd_word_o;
   logic              eoc_o, eolc_o;

   int nchk = 0;
   int nerr = 0;
   logic [DW-1:0] expv [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   msamp_seq #(.NCH(NCH), .DW(DW), .WW(16), .FIRST_CYC(FIRST), .PER_CYC(PER)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we_i (mask_we_i),
      .mask_d_i  (mask_d_i),
      .start_i   (start_i),
      .samp_i    (samp_i),
      .rd_i      (rd_i),
      .rd_word_o (rd_word_o),
      .eoc_o     (eoc_o),
      .eolc_o    (eolc_o)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int seed, input int ch);
      pat = DW'((seed * 397 + ch * 181 + 5) % 4096);
   endfunction

   task automatic set_samples(input int seed);
      for (int ch = 0; ch < NCH; ch++) begin
         expv[ch] = pat(seed, ch);
         samp_i[ch*DW +: DW] = expv[ch];
      end
   endtask

   task automatic garble();
      for (int ch = 0; ch < NCH; ch++) samp_i[ch*DW +: DW] = ~expv[ch];
   endtask

   task automatic write_mask(input logic [7:0] m);
      @(negedge clk);
      mask_we_i = 1'b1;
      mask_d_i  = m;
      @(posedge clk);
      @(negedge clk);
      mask_we_i = 1'b0;
   endtask

   // Called at a falling edge; returns at a falling edge after the accepted start
   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic pulse_read();
      rd_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic read_all(input logic [7:0] m);
      for (int ch = 0; ch < NCH; ch++) begin
         if (m[ch]) begin
            chk(rd_word_o == {4'hF, expv[ch]}, $sformatf("R2 R3 R4 R7 read of ch%0d", ch),
                32'(rd_word_o), 32'({4'hF, expv[ch]}));
            pulse_read();
         end
      end
      chk(rd_word_o == 16'hFFFF, "R3 empty queue word", 32'(rd_word_o), 32'hFFFF);
      pulse_read();
      chk(rd_word_o == 16'hFFFF, "R3 read on empty queue", 32'(rd_word_o), 32'hFFFF);
   endtask

   task automatic run_seq(input logic [7:0] m, input bit wr, input int seed, input int n, input bit rd);
      int t;
      if (wr) write_mask(m);
      set_samples(seed);
      pulse_start();
      garble();
      chk(!eoc_o && !eolc_o && rd_word_o == 16'hFFFF, "R8 start clears flags and queue",
          {14'd0, eoc_o, eolc_o, rd_word_o}, 32'h0000FFFF);
      if (n > 0) begin
         t = FIRST + (n - 1) * PER;
         for (int c = 1; c <= t; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk(eoc_o == (c >= FIRST), $sformatf("R5 first flag at cycle %0d", c),
                32'(eoc_o), 32'(c >= FIRST));
            chk(eolc_o == (c >= t), $sformatf("R6 last flag at cycle %0d", c),
                32'(eolc_o), 32'(c >= t));
         end
         if (rd) read_all(m);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, then default mask converts every channel
      chk(!eoc_o && !eolc_o, "R1 flags low after reset", {31'd0, eoc_o | eolc_o}, 32'd0);
      chk(rd_word_o == 16'hFFFF, "R1 read word after reset", 32'(rd_word_o), 32'hFFFF);
      run_seq(8'hFF, 1'b0, 1, 8, 1'b1);

      // Table walk over several masks (R2..R7)
      for (int v = 0; v < 6; v++) begin
         run_seq(VEC[v][11:4], 1'b1, 10 + v, int'(VEC[v][3:0]), 1'b1);
      end

      // R8: unread results from one sequence vanish at the next start
      run_seq(8'hF0, 1'b1, 30, 4, 1'b0);
      run_seq(8'h03, 1'b1, 31, 2, 1'b1);

      // R10: all-zero mask
      write_mask(8'h00);
      set_samples(40);
      pulse_start();
      for (int c = 1; c <= 30; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (c % 10 == 0)
            chk(!eoc_o && !eolc_o && rd_word_o == 16'hFFFF, "R10 zero mask gives nothing",
                {14'd0, eoc_o, eolc_o, rd_word_o}, 32'h0000FFFF);
      end

      // R9 and R11: start and mask write during a running sequence
      begin
         int t;
         write_mask(8'hFF);
         set_samples(50);
         pulse_start();
         t = FIRST + 7 * PER;
         for (int c = 1; c <= t; c++) begin
            if (c == FIRST + 1) begin
               start_i   = 1'b1;
               mask_we_i = 1'b1;
               mask_d_i  = 8'h01;
               garble();
            end
            @(posedge clk);
            @(negedge clk);
            start_i   = 1'b0;
            mask_we_i = 1'b0;
            chk(eoc_o == (c >= FIRST), $sformatf("R9 first flag kept at cycle %0d", c),
                32'(eoc_o), 32'(c >= FIRST));
            chk(eolc_o == (c >= t), $sformatf("R9 completion time kept at cycle %0d", c),
                32'(eolc_o), 32'(c >= t));
         end
         read_all(8'hFF);
      end
      // R11: the mask written mid-sequence now selects only channel 0
      run_seq(8'h01, 1'b0, 60, 1, 1'b1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule